// File: doc/BRIEF.md
# Bitmap-Selected Header Preprocessor with CRC Hasher

This block sits in a packet pipeline where every packet already begins with a 64-bit control header. It stores the packet while it arrives, collects user-chosen 32-bit words from the packet body, and folds those words into a 32-bit CRC hash. It then writes the hash back into the control header and sends the packet out again, with the header first.

The module bitmap in the incoming header picks, packet by packet, which preprocessing steps run. Bit 0 turns the configurable hasher on. Bit 1 selects flow-key mode, which builds a 240-bit key, hashes it and marks the header for exact-match lookup. Software sets the word offsets and the chunk enables through plain configuration inputs, and these must be held stable while a packet is in flight.

The data path is 64 bits wide. Beat 0 is the header. Payload beat p (the beat that follows the header p+1 beats later) carries payload word 2p in bits [63:32] and payload word 2p+1 in bits [31:0].

Header layout:
- Bits [63:32] hold the hash.
- Bits [31:24] hold the module bitmap.
- Bits [23:16] hold the forwarding mode.
- Bits [15:0] hold the data-plane identifier.

Top module: `bmp_preproc`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: Each accepted packet is sent back out with the same number of beats. The header beat comes first, flagged with out_sop, and the last beat is flagged with out_eop. Every payload beat is unchanged and in its original order.
- R3: When the hasher or flow-key mode is enabled, header bits [63:32] of the output hold a CRC-32 over the 256-bit field. The CRC uses polynomial 0x04C11DB7, starts from all ones, processes bits MSB first, and applies neither reflection nor a final XOR. Chunk 0 is processed first and chunk 7 last.
- R4: Chunk g (0 to 7) takes payload word cfg_chunk_off[6g+5:6g]. An even word index 2p selects bits [63:32] of payload beat p, and an odd index 2p+1 selects bits [31:0] of that beat.
- R5: A chunk contributes 32 zero bits in either of two cases. The first case is that its cfg_chunk_en bit is 0 outside flow-key mode. The second case is that its word offset lies past the end of the packet, which includes the case of a packet that has only a header.
- R6: When bitmap bits 0 and 1 (header bits 24 and 25) are both 0, the hash field is passed through unchanged.
- R7: When bitmap bit 1 (header bit 25) is 1, flow-key mode applies:
  - chunks 0 to 6 are used whatever their enables;
  - chunk 7 keeps only its upper 16 bits, with the low 16 bits forced to zero, giving 240 key bits;
  - the hash is written;
  - the mode field [23:16] becomes 8'h01.
- R8: Header bits [31:24] and [15:0] always pass through unchanged. The mode field [23:16] also passes through unchanged unless flow-key mode is selected.
- R9: From the cycle after the last beat of a packet is accepted until the last output beat is sent, in_ready is 0. in_ready and out_valid are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Block can accept a beat |
| in_sop | input | 1 | First beat of a packet (the header) |
| in_eop | input | 1 | Last beat of a packet |
| in_data | input | 64 | Input beat |
| cfg_chunk_off | input | 48 | Eight 6-bit payload word offsets, chunk g at [6g+5:6g] |
| cfg_chunk_en | input | 8 | Per-chunk enables |
| out_valid | output | 1 | Output beat valid |
| out_sop | output | 1 | Output header beat |
| out_eop | output | 1 | Last output beat |
| out_data | output | 64 | Output beat |

## Verification
The hardest cases to reach are at the edges of word selection. One is a chunk whose offset points past the end of a short packet, so its stale content must not reach the hash. The other is offset 63 in a packet of full length. Directed packets cover both: a header-only packet with every chunk enabled, and a packet with the maximum number of beats whose offsets hit the first word, the last word, and both halves of a beat. Flow-key mode is tested with all enables cleared, which shows that it overrides the enables. The random packets vary the length, the offsets, the enables and the bitmap, so that outside the directed cases chunks land both inside and beyond the packet.

// File: rtl/pp_pkg.sv
package pp_pkg;
  localparam int unsigned BEAT_W    = 64;
  localparam int unsigned CHUNK_W   = 32;
  localparam int unsigned HASH_LSB  = 32;
  localparam int unsigned BMP_LSB   = 24;
  localparam int unsigned MODE_LSB  = 16;
  localparam int unsigned BIT_HASH  = 0;
  localparam int unsigned BIT_FLOW  = 1;
  localparam logic [7:0]  MODE_EXACT = 8'h01;
  localparam logic [31:0] CRC_POLY  = 32'h04C11DB7;

  typedef enum logic [1:0] {ST_RX, ST_HASH, ST_TX} pp_state_e;

  function automatic logic [31:0] crc32_word(input logic [31:0] c_in,
                                             input logic [31:0] d);
    logic [31:0] c;
    logic fb;
    c = c_in;
    for (int i = 31; i >= 0; i--) begin
      fb = c[31] ^ d[i];
      c  = {c[30:0], 1'b0};
      if (fb) c = c ^ CRC_POLY;
    end
    return c;
  endfunction
endpackage

// File: rtl/pp_pktbuf.sv
module pp_pktbuf #(
  parameter int unsigned DEPTH = 33,
  parameter int unsigned WIDTH = 64,
  localparam int unsigned AW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_data
);
  logic [WIDTH-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en && (wr_addr < AW'(DEPTH))) mem_q[wr_addr] <= wr_data;
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr < AW'(DEPTH)) rd_data = mem_q[rd_addr];
  end
endmodule

// File: rtl/pp_gather.sv
module pp_gather #(
  parameter int unsigned NCHUNK = 8,
  parameter int unsigned OFF_W  = 6,
  localparam int unsigned IDX_W = OFF_W - 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr,
  input  logic                         cap_en,
  input  logic [IDX_W-1:0]             beat_idx,
  input  logic [63:0]                  beat_data,
  input  logic [NCHUNK*OFF_W-1:0]      cfg_off,
  input  logic [NCHUNK-1:0]            cfg_en,
  input  logic                         flow_mode,
  output logic [NCHUNK-1:0][31:0]      field
);
  logic [NCHUNK-1:0][31:0] chunk_q, chunk_d;

  for (genvar g = 0; g < NCHUNK; g++) begin : g_chunk
    logic [OFF_W-1:0] off_g;
    logic             hit;
    assign off_g = cfg_off[g*OFF_W +: OFF_W];
    assign hit   = cap_en && (off_g[OFF_W-1:1] == beat_idx);

    always_comb begin
      chunk_d[g] = chunk_q[g];
      if (clr)      chunk_d[g] = '0;
      else if (hit) chunk_d[g] = off_g[0] ? beat_data[31:0] : beat_data[63:32];
    end

    if (g == NCHUNK - 1) begin : g_last
      always_comb begin
        if (flow_mode)      field[g] = {chunk_q[g][31:16], 16'h0000};
        else if (cfg_en[g]) field[g] = chunk_q[g];
        else                field[g] = '0;
      end
    end else begin : g_mid
      assign field[g] = (flow_mode || cfg_en[g]) ? chunk_q[g] : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chunk_q <= '0;
    else if (clr || cap_en) chunk_q <= chunk_d;
  end

  // R4
  chunk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !cap_en) |=> $stable(chunk_q));
endmodule

// File: rtl/pp_crc.sv
module pp_crc (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init,
  input  logic        step,
  input  logic [31:0] din,
  output logic [31:0] crc
);
  import pp_pkg::*;
  logic [31:0] crc_q, crc_d;

  always_comb begin
    crc_d = crc_q;
    if (init)      crc_d = 32'hFFFF_FFFF;
    else if (step) crc_d = crc32_word(crc_q, din);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= 32'hFFFF_FFFF;
    else if (init || step) crc_q <= crc_d;
  end

  assign crc = crc_q;

  // R3
  crc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!init && !step) |=> $stable(crc_q));
endmodule

// File: rtl/bmp_preproc.sv
module bmp_preproc #(
  parameter int unsigned NCHUNK = 8,
  parameter int unsigned OFF_W  = 6,
  localparam int unsigned PAY_BEATS = (1 << OFF_W) / 2,
  localparam int unsigned DEPTH     = PAY_BEATS + 1,
  localparam int unsigned AW        = $clog2(DEPTH + 1),
  localparam int unsigned HC_W      = $clog2(NCHUNK)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic                    in_sop,
  input  logic                    in_eop,
  input  logic [63:0]             in_data,
  input  logic [NCHUNK*OFF_W-1:0] cfg_chunk_off,
  input  logic [NCHUNK-1:0]       cfg_chunk_en,
  output logic                    out_valid,
  output logic                    out_sop,
  output logic                    out_eop,
  output logic [63:0]             out_data
);
  import pp_pkg::*;

  logic [1:0] rst_sync_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  pp_state_e       state_q, state_d;
  logic [AW-1:0]   wr_cnt_q, wr_cnt_d, last_q, last_d, rd_cnt_q, rd_cnt_d;
  logic [HC_W-1:0] hcnt_q, hcnt_d;

  logic          accept, wr_en, pay_beat, hash_on, flow_on;
  logic [AW-1:0] wr_addr, pay_idx;
  logic [63:0]   rd_data;
  logic [NCHUNK-1:0][31:0] field;
  logic [31:0]   crc;
  logic [7:0]    bitmap;

  assign accept   = in_valid && in_ready;
  assign wr_addr  = in_sop ? '0 : wr_cnt_q;
  assign wr_en    = accept;
  assign pay_beat = accept && (wr_addr != '0) && (wr_addr <= AW'(PAY_BEATS));
  assign pay_idx  = wr_addr - AW'(1);

  pp_pktbuf #(.DEPTH(DEPTH), .WIDTH(64)) u_buf (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(in_data),
    .rd_addr(rd_cnt_q), .rd_data(rd_data)
  );

  logic [63:0] hdr_q;
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) hdr_q <= '0;
    else if (accept && wr_addr == '0) hdr_q <= in_data;
  end
  assign bitmap  = hdr_q[BMP_LSB +: 8];
  assign flow_on = bitmap[BIT_FLOW];
  assign hash_on = bitmap[BIT_HASH] || flow_on;

  pp_gather #(.NCHUNK(NCHUNK), .OFF_W(OFF_W)) u_gather (
    .clk(clk), .rst_n(rst_ni),
    .clr(accept && wr_addr == '0),
    .cap_en(pay_beat),
    .beat_idx(pay_idx[OFF_W-2:0]),
    .beat_data(in_data),
    .cfg_off(cfg_chunk_off),
    .cfg_en(cfg_chunk_en),
    .flow_mode(flow_on),
    .field(field)
  );

  pp_crc u_crc (
    .clk(clk), .rst_n(rst_ni),
    .init(accept && in_eop),
    .step(state_q == ST_HASH),
    .din(field[hcnt_q]),
    .crc(crc)
  );

  always_comb begin
    state_d  = state_q;
    wr_cnt_d = wr_cnt_q;
    last_d   = last_q;
    rd_cnt_d = rd_cnt_q;
    hcnt_d   = hcnt_q;
    unique case (state_q)
      ST_RX: begin
        if (accept) begin
          wr_cnt_d = wr_addr + AW'(1);
          if (in_eop) begin
            last_d  = (wr_addr < AW'(DEPTH)) ? wr_addr : AW'(DEPTH - 1);
            hcnt_d  = '0;
            state_d = ST_HASH;
          end
        end
      end
      ST_HASH: begin
        hcnt_d = hcnt_q + HC_W'(1);
        if (hcnt_q == HC_W'(NCHUNK - 1)) begin
          rd_cnt_d = '0;
          state_d  = ST_TX;
        end
      end
      ST_TX: begin
        rd_cnt_d = rd_cnt_q + AW'(1);
        if (rd_cnt_q == last_q) begin
          wr_cnt_d = '0;
          state_d  = ST_RX;
        end
      end
      default: state_d = ST_RX;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_RX;
      wr_cnt_q <= '0;
      last_q   <= '0;
      rd_cnt_q <= '0;
      hcnt_q   <= '0;
    end else begin
      state_q  <= state_d;
      wr_cnt_q <= wr_cnt_d;
      last_q   <= last_d;
      rd_cnt_q <= rd_cnt_d;
      hcnt_q   <= hcnt_d;
    end
  end

  logic [63:0] hdr_out;
  always_comb begin
    hdr_out = rd_data;
    if (hash_on) hdr_out[HASH_LSB +: 32] = crc;
    if (flow_on) hdr_out[MODE_LSB +: 8]  = MODE_EXACT;
  end

  assign in_ready  = (state_q == ST_RX);
  assign out_valid = (state_q == ST_TX);
  assign out_sop   = out_valid && (rd_cnt_q == '0);
  assign out_eop   = out_valid && (rd_cnt_q == last_q);
  assign out_data  = !out_valid ? '0 : (rd_cnt_q == '0) ? hdr_out : rd_data;

  // R9
  ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !(in_ready && out_valid));
  // R2
  tx_contig_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (out_valid && !out_eop) |=> out_valid);
  // R6
  hash_pass_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (out_sop && !hash_on) |-> (out_data[63:32] == hdr_q[63:32]));
  // R7
  mode_exact_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (out_sop && flow_on) |-> (out_data[23:16] == MODE_EXACT));
  // R8
  hdr_keep_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    out_sop |-> (out_data[31:24] == hdr_q[31:24] && out_data[15:0] == hdr_q[15:0]));
endmodule

// File: tb/bmp_preproc_tb.sv
module bmp_preproc_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
  logic [63:0] in_data = '0;
  logic [47:0] cfg_chunk_off = '0;
  logic [7:0]  cfg_chunk_en = '0;
  logic in_ready, out_valid, out_sop, out_eop;
  logic [63:0] out_data;

  int errs = 0, checks = 0, cycles = 0;
  logic [63:0] pkt [0:32];
  logic [63:0] got [0:40];
  int got_n = 0;
  logic got_sop_ok = 1'b1;
  logic overlap = 1'b0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  bmp_preproc u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sop(in_sop), .in_eop(in_eop), .in_data(in_data),
    .cfg_chunk_off(cfg_chunk_off), .cfg_chunk_en(cfg_chunk_en),
    .out_valid(out_valid), .out_sop(out_sop), .out_eop(out_eop), .out_data(out_data)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; errs++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      finish_run();
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (in_ready && out_valid) overlap = 1'b1;
      if (out_valid && got_n <= 40) begin
        if ((got_n == 0) != out_sop) got_sop_ok = 1'b0;
        got[got_n] = out_data;
        got_n++;
        if (out_eop) done = 1'b1;
      end
    end
  end

  function automatic logic [31:0] crc_ref(input logic [255:0] f);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int i = 255; i >= 0; i--) begin
      logic fb = c[31] ^ f[i];
      c = {c[30:0], 1'b0};
      if (fb) c = c ^ 32'h04C11DB7;
    end
    return c;
  endfunction

  function automatic logic [63:0] exp_hdr(input int nb);
    logic [255:0] f = '0;
    logic [63:0] h = pkt[0];
    logic flow = h[25];
    for (int g = 0; g < 8; g++) begin
      int w = int'(cfg_chunk_off[g*6 +: 6]);
      logic [31:0] v = '0;
      if (w / 2 < nb - 1) v = (w % 2 == 1) ? pkt[1 + w/2][31:0] : pkt[1 + w/2][63:32];
      if (flow) begin
        if (g == 7) v[15:0] = 16'h0;
      end else if (!cfg_chunk_en[g]) v = '0;
      f[255 - g*32 -: 32] = v;
    end
    if (h[24] || flow) h[63:32] = crc_ref(f);
    if (flow) h[23:16] = 8'h01;
    return h;
  endfunction

  task automatic run_pkt(input int nb, input string tag);
    logic [63:0] eh;
    bit pay_ok = 1'b1;
    while (!in_ready) @(negedge clk);
    for (int b = 0; b < nb; b++) begin
      in_valid = 1'b1; in_sop = (b == 0); in_eop = (b == nb - 1); in_data = pkt[b];
      @(negedge clk);
    end
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    chk(!in_ready, {"R9 ready low after eop ", tag}, {63'd0, in_ready}, 64'd0);
    while (!done) @(negedge clk);
    eh = exp_hdr(nb);
    chk(got_n == nb, {"R2 beat count ", tag}, 64'(got_n), 64'(nb));
    chk(got_sop_ok, {"R2 sop placement ", tag}, {63'd0, got_sop_ok}, 64'd1);
    chk(got[0][63:32] == eh[63:32], {"R3 R4 R5 R6 hash ", tag}, {32'd0, got[0][63:32]}, {32'd0, eh[63:32]});
    chk(got[0][31:0] == eh[31:0], {"R7 R8 header fields ", tag}, {32'd0, got[0][31:0]}, {32'd0, eh[31:0]});
    for (int b = 1; b < nb; b++) if (got[b] !== pkt[b]) pay_ok = 1'b0;
    chk(pay_ok, {"R2 payload ", tag}, {63'd0, pay_ok}, 64'd1);
    chk(!overlap, {"R9 ready/valid overlap ", tag}, {63'd0, overlap}, 64'd0);
    done = 1'b0; got_n = 0; got_sop_ok = 1'b1;
  endtask

  task automatic fill(input int nb, input logic [7:0] bm);
    for (int b = 0; b < nb; b++) pkt[b] = {$urandom, $urandom};
    pkt[0][31:24] = bm;
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1
    chk(!out_valid, "R1 out_valid after reset", {63'd0, out_valid}, 64'd0);
    chk(in_ready, "R1 in_ready after reset", {63'd0, in_ready}, 64'd1);

    cfg_chunk_en = 8'hFF; cfg_chunk_off = {$urandom, $urandom};
    fill(1, 8'h01); run_pkt(1, "hdr-only");
    cfg_chunk_off = {6'd63, 6'd62, 6'd1, 6'd0, 6'd33, 6'd32, 6'd7, 6'd40};
    fill(33, 8'h01); run_pkt(33, "full-len");
    fill(5, 8'h00); run_pkt(5, "bypass");
    cfg_chunk_en = 8'h00; cfg_chunk_off = {6'd5, 6'd4, 6'd3, 6'd2, 6'd1, 6'd0, 6'd7, 6'd6};
    fill(6, 8'h02); run_pkt(6, "flow-key");
    fill(6, 8'h01); run_pkt(6, "all-off");
    cfg_chunk_en = 8'hA5; cfg_chunk_off = {8{6'd20}};
    fill(4, 8'h01); run_pkt(4, "beyond-end");

    for (int k = 0; k < 40; k++) begin
      int nb = 1 + int'($urandom_range(32, 0));
      cfg_chunk_en  = 8'($urandom);
      cfg_chunk_off = {$urandom, $urandom};
      fill(nb, 8'($urandom));
      run_pkt(nb, "random");
    end
    finish_run();
  end
endmodule